// File: doc/BRIEF.md
# Multi-byte synchronous serial master

This block is a clock-generating serial master. One transfer sends one to three bytes. It can then, if asked, receive a single byte. The transfer setup is presented on parallel inputs and taken in with a one-cycle start strobe:

- the transmit bytes and the byte count;
- a receive-enable bit;
- the bit order;
- the clock idle level and the clock phase;
- a two-bit chip-select mask;
- a divider code.

The block then drives the serial clock, the data output with its own output enable, and two active-low chip selects. It samples the serial data input and reports busy, a one-cycle done pulse and the received byte.

A half-period tick generator sets the pace. Its period is 1, 2 or 4 system cycles, chosen by the divider code. A four-state machine sequences each transfer:

- **IDLE** moves to **LEAD** when a start is accepted. In that cycle the configuration is captured and the masked chip selects assert.
- **LEAD** moves to **SHIFT** on the first tick, which also makes the first clock edge.
- **SHIFT** moves to **TRAIL** on the tick that makes the last clock edge.
- **TRAIL** moves back to **IDLE** on the next tick. On that tick the chip selects release and done pulses.

A shift unit chooses each outgoing bit from the captured bytes and assembles the received byte.

Top module: `mbs_master`

## Requirements
- R1: `byte_cnt` sets the number of bytes written: 1, 2 or 3, with 0 treated as 1. Each byte is 8 bits. `tx_bytes[7:0]` goes first, then `[15:8]`, then `[23:16]`.
- R2: With `rx_en`=1, exactly 8 more bits are clocked after the write bits, and the assembled byte appears on `rx_data` by the done pulse. While a receive bit is sampled, `mosi_oe` is 0. `mosi` keeps its last value while `mosi_oe` is 0.
- R3: `lsb_first`=1 sends bit 0 of each byte first and places the first received bit at `rx_data[0]`. `lsb_first`=0 sends bit 7 first and places the first received bit at `rx_data[7]`.
- R4: The leading edge is the transition of `sclk` away from `cpol`. With `cpha`=0, data is valid before the leading edge, is sampled on the leading edge and changes on the trailing edge. With `cpha`=1, data changes on the leading edge and is sampled on the trailing edge.
- R5: While idle, `sclk` equals the `cpol` input seen one cycle earlier. Every transfer ends with `sclk` back at its idle level.
- R6: `cs_n[i]` is driven low for the whole transfer when `cs_mask[i]`=1; both may be low together. The chip selects assert in the cycle after start is accepted. The first `sclk` edge follows H cycles later, and the release comes H cycles after the last edge.
- R7: The half period H in system cycles is 1 for `div_sel`=000, 2 for 001 and 4 for 010. That gives `sclk` at the system clock divided by 2, 4 or 8.
- R8: `div_sel` codes 011 through 111 behave as 010 (H=4).
- R9: `done` is high for exactly one cycle, the cycle in which the chip selects have just released. `busy` is high from the cycle after an accepted start until that cycle, and low during it.
- R10: A start while `busy`=1 is ignored. The setup inputs are captured at the accepted start, and later changes to them have no effect on the running transfer.
- R11: A start presented in the cycle that `done` is high is accepted and begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| tx_bytes | input | 24 | Transmit bytes, byte 0 in the low bits |
| byte_cnt | input | 2 | Number of bytes to write (0 treated as 1) |
| rx_en | input | 1 | Receive one byte after the write phase |
| lsb_first | input | 1 | Bit order: 1 = LSB first |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| cs_mask | input | 2 | Chip selects to assert |
| div_sel | input | 3 | Shift clock divider code |
| miso | input | 1 | Serial data input |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data output |
| mosi_oe | output | 1 | Data output enable, low during receive |
| cs_n | output | 2 | Active-low chip selects |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | 8 | Received byte |

## Verification
The done pulse and a new start strobe can fall in the same cycle. The bench finishes a receiving transfer and, in the cycle where done is seen high, raises start with a different setup. It judges the first transfer by the `rx_data` value present during done. It then requires `busy` to be high and the chip selects to show the second mask one cycle later. Finally, the second transfer must run to completion with its own clock mode, bit order and edge count, which shows that its setup was captured cleanly in the done cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int MBS_MAX_LOG2 = 2;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_SHIFT,
        S_TRAIL
    } mbs_state_e;

    // divider code -> log2 of the half period; codes above the last legal one clamp
    function automatic logic [1:0] half_log2_of(input logic [7:0] code);
        if (code > 8'(MBS_MAX_LOG2)) begin
            return 2'(MBS_MAX_LOG2);
        end
        return code[1:0];
    endfunction

endpackage

// File: rtl/mbs_tick.sv
module mbs_tick #(
    parameter int MAX_LOG2 = 2,
    localparam int CW = MAX_LOG2 + 1,
    localparam int LW = $clog2(MAX_LOG2 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [LW-1:0] half_log2,
    output logic          tick
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = (CW'(1) << half_log2) - CW'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_log2 != '0 && $stable(half_log2)) |=> !tick); // R7

endmodule

// File: rtl/mbs_shreg.sv
module mbs_shreg #(
    parameter int BYTE_W = 8,
    parameter int MAX_BYTES = 3,
    localparam int TX_W = BYTE_W * MAX_BYTES,
    localparam int BI_W = $clog2(BYTE_W * (MAX_BYTES + 1) + 1),
    localparam int EW = BI_W + 1,
    localparam int LB = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              finish,
    input  logic              edge_fire,
    input  logic [EW-1:0]     edge_cnt,
    input  logic [TX_W-1:0]   tx,
    input  logic [BI_W-1:0]   wbits,
    input  logic              lsb_first,
    input  logic              cpha,
    input  logic              miso,
    output logic              mosi,
    output logic              mosi_oe,
    output logic [BYTE_W-1:0] rx_byte
);

    logic            leading;
    logic            shift_edge;
    logic            rx_take;
    logic [BI_W-1:0] bidx;
    logic [BI_W-1:0] oidx;
    logic [BI_W-1:0] sel;
    logic [TX_W-1:0] tx_sh;

    assign leading    = ~edge_cnt[0];
    assign bidx       = edge_cnt[EW-1:1];
    assign shift_edge = cpha ? leading : ~leading;
    assign oidx       = load ? '0 : (cpha ? bidx : bidx + BI_W'(1));
    assign sel        = {oidx[BI_W-1:LB], lsb_first ? oidx[LB-1:0] : ~oidx[LB-1:0]};
    assign tx_sh      = tx >> sel;
    assign rx_take    = edge_fire && !shift_edge && (bidx >= wbits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mosi    <= 1'b0;
            mosi_oe <= 1'b0;
            rx_byte <= '0;
        end else if (load) begin
            mosi    <= tx_sh[0];
            mosi_oe <= 1'b1;
            rx_byte <= '0;
        end else begin
            if (finish) begin
                mosi_oe <= 1'b0;
            end
            if (edge_fire && shift_edge) begin
                if (oidx < wbits) begin
                    mosi <= tx_sh[0];
                end else begin
                    mosi_oe <= 1'b0;
                end
            end
            if (rx_take) begin
                rx_byte <= lsb_first ? {miso, rx_byte[BYTE_W-1:1]}
                                     : {rx_byte[BYTE_W-2:0], miso};
            end
        end
    end

    AST_RX_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> !mosi_oe); // R2
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mosi_oe && $past(!mosi_oe)) |-> $stable(mosi)); // R2

endmodule

// File: rtl/mbs_master.sv
module mbs_master
    import mbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MAX_BYTES = 3,
    parameter int DIV_W = 3,
    localparam int NB_W = $clog2(MAX_BYTES + 1),
    localparam int TX_W = BYTE_W * MAX_BYTES,
    localparam int BI_W = $clog2(BYTE_W * (MAX_BYTES + 1) + 1),
    localparam int EW = BI_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TX_W-1:0]   tx_bytes,
    input  logic [NB_W-1:0]   byte_cnt,
    input  logic              rx_en,
    input  logic              lsb_first,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [1:0]        cs_mask,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              mosi_oe,
    output logic [1:0]        cs_n,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_data
);

    mbs_state_e state, state_nxt;

    logic            tick;
    logic            edge_fire;
    logic            idle;
    logic            accept;
    logic            finish;
    logic [TX_W-1:0] tx_q;
    logic [NB_W-1:0] nb_q;
    logic [NB_W-1:0] nb_in;
    logic            rx_q;
    logic            lsb_q;
    logic            cpha_q;
    logic [1:0]      hlog_q;
    logic [EW-1:0]   edge_cnt;
    logic [EW-1:0]   last_edge;
    logic [BI_W-1:0] wbits;
    logic [BI_W-1:0] tbits;
    logic            sclk_q;
    logic [1:0]      cs_q;
    logic            done_q;

    assign idle      = (state == S_IDLE);
    assign accept    = idle && start;
    assign finish    = (state == S_TRAIL) && tick;
    assign edge_fire = tick && (state == S_LEAD || state == S_SHIFT);
    assign nb_in     = (byte_cnt == '0) ? NB_W'(1)
                     : ((int'(byte_cnt) > MAX_BYTES) ? NB_W'(MAX_BYTES) : byte_cnt);
    assign wbits     = BI_W'(int'(nb_q) * BYTE_W);
    assign tbits     = wbits + (rx_q ? BI_W'(BYTE_W) : '0);
    assign last_edge = {tbits, 1'b0} - EW'(1);

    mbs_tick #(
        .MAX_LOG2 (MBS_MAX_LOG2)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (!idle),
        .half_log2 (hlog_q),
        .tick      (tick)
    );

    mbs_shreg #(
        .BYTE_W    (BYTE_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .finish    (finish),
        .edge_fire (edge_fire),
        .edge_cnt  (edge_cnt),
        .tx        (accept ? tx_bytes : tx_q),
        .wbits     (wbits),
        .lsb_first (accept ? lsb_first : lsb_q),
        .cpha      (cpha_q),
        .miso      (miso),
        .mosi      (mosi),
        .mosi_oe   (mosi_oe),
        .rx_byte   (rx_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (start) state_nxt = S_LEAD;
            S_LEAD:  if (tick) state_nxt = S_SHIFT;
            S_SHIFT: if (tick && edge_cnt == last_edge) state_nxt = S_TRAIL;
            S_TRAIL: if (tick) state_nxt = S_IDLE;
        endcase
    end

    // outputs and captured setup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            cs_q     <= 2'b11;
            done_q   <= 1'b0;
            edge_cnt <= '0;
            tx_q     <= '0;
            nb_q     <= NB_W'(1);
            rx_q     <= 1'b0;
            lsb_q    <= 1'b0;
            cpha_q   <= 1'b0;
            hlog_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    sclk_q <= cpol;
                    if (start) begin
                        cs_q     <= ~cs_mask;
                        edge_cnt <= '0;
                        tx_q     <= tx_bytes;
                        nb_q     <= nb_in;
                        rx_q     <= rx_en;
                        lsb_q    <= lsb_first;
                        cpha_q   <= cpha;
                        hlog_q   <= half_log2_of(8'(div_sel));
                    end
                end
                S_LEAD, S_SHIFT: begin
                    if (tick) begin
                        sclk_q   <= ~sclk_q;
                        edge_cnt <= edge_cnt + EW'(1);
                    end
                end
                S_TRAIL: begin
                    if (tick) begin
                        cs_q   <= 2'b11;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign sclk = sclk_q;
    assign cs_n = cs_q;
    assign done = done_q;
    assign busy = !idle;

    AST_CS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cs_n == ~$past(cs_mask))); // R6
    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(rst_n)) |-> (sclk == $past(cpol))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && cs_n == 2'b11)); // R9
    AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(nb_q) && $stable(cpha_q) && $stable(cs_q) && $stable(hlog_q))); // R10

endmodule

// File: tb/mbs_master_bench.sv
module mbs_master_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [23:0] tx_bytes;
    logic [1:0]  byte_cnt;
    logic        rx_en, lsb_first, cpol, cpha;
    logic [1:0]  cs_mask;
    logic [2:0]  div_sel;
    logic        miso = 1'b0;
    logic        sclk, mosi, mosi_oe, busy, done;
    logic [1:0]  cs_n;
    logic [7:0]  rx_data;

    always #4 clk = ~clk;

    mbs_master u_mbs_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_bytes(tx_bytes),
        .byte_cnt(byte_cnt), .rx_en(rx_en), .lsb_first(lsb_first), .cpol(cpol),
        .cpha(cpha), .cs_mask(cs_mask), .div_sel(div_sel), .miso(miso),
        .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .cs_n(cs_n), .busy(busy),
        .done(done), .rx_data(rx_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    // expected setup of the running transfer
    logic [23:0] e_tx;
    logic [7:0]  e_resp;
    int e_nb, e_h;
    bit e_rx, e_lsb, e_cpol, e_cpha;
    logic [1:0] e_mask;

    // slave monitor state
    int cyc = 0, edges = 0, le = 0, se = 0, cs_cyc = 0, last_cyc = 0;
    int lead = 0, trail = 0, oe_err = 0, dones = 0, done_err = 0;
    logic [31:0] cap = '0;
    logic [1:0]  cs_seen = 2'b11;
    logic prev_sclk = 1'b0, prev_act = 1'b0, prev_done = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic slave_bit(input int idx);
        int j;
        if (idx >= e_nb * 8 && idx < e_nb * 8 + 8) begin
            j = idx - e_nb * 8;
            return e_lsb ? e_resp[j] : e_resp[7 - j];
        end
        return 1'b0;
    endfunction

    function automatic logic exp_bit(input int k);
        int by, j;
        by = k / 8;
        j  = k % 8;
        return e_tx[by * 8 + (e_lsb ? j : 7 - j)];
    endfunction

    always @(negedge clk) begin
        logic act, lead_e;
        cyc++;
        act = (cs_n != 2'b11);
        if (act && !prev_act) begin
            edges = 0; le = 0; se = 0; cap = '0; oe_err = 0;
            cs_seen = cs_n; cs_cyc = cyc; lead = -1;
            miso = slave_bit(0);
        end else if (act && sclk != prev_sclk) begin
            if (edges == 0) lead = cyc - cs_cyc;
            edges++;
            last_cyc = cyc;
            lead_e = (sclk != e_cpol);
            if (lead_e == !e_cpha) begin
                if (le < e_nb * 8) begin
                    cap[le] = mosi;
                    if (!mosi_oe) oe_err++;
                end else if (mosi_oe) begin
                    oe_err++;
                end
                le++;
            end else begin
                se++;
                miso = slave_bit(e_cpha ? se - 1 : se);
            end
        end
        if (!act && prev_act) trail = cyc - last_cyc;
        if (done && prev_done) done_err++;
        if (done) dones++;
        prev_done = done;
        prev_act  = act;
        prev_sclk = sclk;
    end

    // caller stands just after a falling edge
    task automatic launch(input logic [23:0] tx, input int cnt, input bit rx, input bit lsb,
                          input bit cp, input bit ph, input logic [1:0] mk, input logic [2:0] dv,
                          input logic [7:0] resp);
        e_tx = tx; e_nb = (cnt == 0) ? 1 : cnt; e_rx = rx; e_lsb = lsb; e_cpol = cp;
        e_cpha = ph; e_mask = mk; e_resp = resp; e_h = 1 << ((dv > 3'd2) ? 2 : int'(dv));
        tx_bytes = tx; byte_cnt = 2'(cnt); rx_en = rx; lsb_first = lsb; cpol = cp;
        cpha = ph; cs_mask = mk; div_sel = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_xfer(input string tag, input int d0);
        int w;
        int bad;
        w = 0;
        while (!done && w < 4000) begin
            @(negedge clk);
            w++;
        end
        #1;
        if (!done) begin
            check(1'b0, tag, "watchdog waiting for done", 0, 1);
            return;
        end
        bad = 0;
        for (int k = 0; k < e_nb * 8; k++) if (cap[k] !== exp_bit(k)) bad++;
        check(bad == 0, {tag, " R1 R3 R4"}, "write bits wrong", bad, 0);
        check(edges == 2 * (e_nb * 8 + (e_rx ? 8 : 0)), {tag, " R1 R2"}, "sclk edges", edges,
              2 * (e_nb * 8 + (e_rx ? 8 : 0)));
        check(lead == e_h, {tag, " R6 R7"}, "cs to first edge", lead, e_h);
        check(trail == e_h, {tag, " R6 R7"}, "last edge to cs release", trail, e_h);
        check(cs_seen == ~e_mask, {tag, " R6"}, "chip selects", int'(cs_seen), int'(~e_mask));
        check(oe_err == 0, {tag, " R2"}, "mosi_oe phase errors", oe_err, 0);
        check(sclk == e_cpol, {tag, " R5"}, "sclk rest level", int'(sclk), int'(e_cpol));
        check(!busy && dones - d0 == 1, {tag, " R9"}, "done count / busy", dones - d0, 1);
        if (e_rx) check(rx_data == e_resp, {tag, " R2 R3"}, "rx_data", int'(rx_data), int'(e_resp));
    endtask

    task automatic t_reset();
        check(cs_n == 2'b11, "R6", "cs_n after reset", int'(cs_n), 3);
        check(!busy && !done, "R9", "busy/done after reset", int'({busy, done}), 0);
        check(sclk == 1'b0 && !mosi_oe, "R5", "sclk/oe after reset", int'({sclk, mosi_oe}), 0);
    endtask

    task automatic t_basic();
        int d0 = dones;
        launch(24'h0000A5, 1, 0, 0, 0, 0, 2'b01, 3'd0, 8'h00);
        finish_xfer("R1 mode0 div2", d0);
    endtask

    task automatic t_three_lsb();
        int d0 = dones;
        launch(24'h3C5AC3, 3, 0, 1, 1, 1, 2'b10, 3'd1, 8'h00);
        finish_xfer("R3 R4 mode3 div4", d0);
    endtask

    task automatic t_rx_mode2();
        int d0 = dones;
        launch(24'h00817E, 2, 1, 1, 1, 0, 2'b11, 3'd2, 8'hB4);
        finish_xfer("R2 both cs div8", d0);
    endtask

    task automatic t_rx_reserved();
        int d0 = dones;
        launch(24'hF00F96, 3, 1, 0, 0, 1, 2'b01, 3'd5, 8'h6D);
        finish_xfer("R8 code5", d0);
    endtask

    task automatic t_zero_count();
        int d0 = dones;
        launch(24'hEE0042, 0, 0, 0, 0, 1, 2'b10, 3'd7, 8'h00);
        finish_xfer("R1 R8 count0 code7", d0);
    endtask

    task automatic t_ignore_start();
        int d0 = dones;
        launch(24'h00C0DE, 2, 1, 0, 1, 1, 2'b01, 3'd1, 8'h35);
        repeat (10) @(negedge clk);
        tx_bytes = 24'h123456; byte_cnt = 2'd3; cpha = 1'b0; cs_mask = 2'b10;
        div_sel = 3'd0; lsb_first = 1'b1; rx_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_xfer("R10 start while busy", d0);
        repeat (4) @(negedge clk);
        check(!busy && cs_n == 2'b11 && dones - d0 == 1, "R10", "no queued transfer",
              int'({busy, cs_n}), 3);
    endtask

    task automatic t_back_to_back();
        int d0 = dones;
        launch(24'h000011, 1, 1, 0, 0, 0, 2'b10, 3'd0, 8'h9A);
        finish_xfer("R11 first", d0);
        d0 = dones;
        launch(24'h002233, 2, 0, 1, 1, 0, 2'b01, 3'd1, 8'h00);
        check(busy && cs_n == 2'b10, "R11", "start in done cycle accepted", int'({busy, cs_n}), 6);
        finish_xfer("R11 second", d0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; tx_bytes = '0; byte_cnt = '0; rx_en = 1'b0;
        lsb_first = 1'b0; cpol = 1'b0; cpha = 1'b0; cs_mask = '0; div_sel = '0;
        e_tx = '0; e_resp = '0; e_nb = 1; e_h = 1; e_rx = 0; e_lsb = 0; e_cpol = 0;
        e_cpha = 0; e_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        @(negedge clk);
        t_three_lsb();
        @(negedge clk);
        t_rx_mode2();
        @(negedge clk);
        t_rx_reserved();
        @(negedge clk);
        t_zero_count();
        @(negedge clk);
        t_ignore_start();
        @(negedge clk);
        t_back_to_back();
        check(done_err == 0, "R9", "done wider than one cycle", done_err, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule